// File: doc/BRIEF.md
# Accumulated-Count Display Timing Generator

This block produces the horizontal sync, vertical sync and data-enable pins for a parallel RGB panel, together with the current scan position and an in-window flag. Frame geometry is not entered as separate porch lengths. Each register field holds a running boundary. The sync field holds the pulse width minus one. The back-porch field adds the back porch to that value. The active field adds the visible size on top. The total field adds the front porch as well. The scan logic therefore only compares its counters against fixed edges and never adds lengths together.

Software writes the geometry into a shadow bank. A reload request then copies the bank into the working set, either on the next clock or at the clock edge that ends the last visible line. Either kind of copy sets a reload-done status flag. The block also keeps three more status flags: a programmable line event, a FIFO underrun and a transfer error. Each flag has its own enable bit and can be cleared by writing a one. The enabled flags are combined into a single interrupt line.

Top module: `acc_timing_gen`

## Requirements
- R1: Writes to address 0 (sync), 1 (back porch), 2 (active), 3 (total) and 9 (line position) land in a shadow copy. In each of these registers the horizontal field is at bits [27:16] and the vertical field at bits [10:0]. The shadow copy reads back at the same address, and it does not alter the scan until a reload copies it.
- R2: Writing 1 in bit 0 of address 5 copies the whole shadow bank on the next clock. Address 5 reads bit 0 as 1 for exactly one cycle and then 0. The same copy sets status bit 3.
- R3: Writing 1 in bit 1 of address 5 defers the copy to the edge at which x equals the total width and y equals the accumulated active height. Bit 1 reads back as 1 until that edge, and status bit 3 sets at that edge. The new geometry governs the scan from the following line onward.
- R4: While enabled, x counts up from 0 to the total width and then returns to 0, and each return advances y. Y returns to 0 after the total height.
- R5: The horizontal sync is active while x is at or below the sync width field. The vertical sync is active while y is at or below the sync height field.
- R6: Data-enable and `active_o` are asserted only when x lies above the accumulated horizontal back porch and at or below the accumulated active width, and y meets the same rule with the vertical fields.
- R7: In the control word at address 4, bits 31, 30 and 29 set hsync, vsync and data-enable active high when 1 and active low when 0. Bit 28 drives `pclk_inv_o`.
- R8: While bit 0 of the control word is 0, the sync and data-enable pins sit at their inactive levels and `active_o` is low at once. The position returns to (0,0) on the next clock and stays there.
- R9: Status bit 0 (line event) sets one clock after the scan stands at x = 0 on the line held in the working line-position register.
- R10: A one-cycle pulse on `fifo_underrun_i` sets status bit 1, and a pulse on `xfer_err_i` sets status bit 2. Each flag is visible one clock later.
- R11: Status reads at address 7. Writing ones to address 8 clears the matching status bits. An event that arrives in the same cycle as the clear keeps its bit set.
- R12: `irq_o` is high exactly when some status bit is set and its enable bit is also set. The enable register is at address 6 and uses the same bit positions as status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| fifo_underrun_i | input | 1 | Underrun event pulse |
| xfer_err_i | input | 1 | Transfer error event pulse |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| de_o | output | 1 | Data-enable pin |
| pclk_inv_o | output | 1 | Select inverted pixel-clock edge |
| pos_x_o | output | HW | Current horizontal count |
| pos_y_o | output | VW | Current line count |
| active_o | output | 1 | Scan is inside the visible window (active high) |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bound checker watches properties of the scan on every cycle. It checks that x steps by one and y holds between line wraps, and that the position is held at the origin while the block is disabled. It also checks that the visible window never includes column 0 or line 0, that an immediate reload request lasts one cycle, that the reload-done flag rises only after a pending request, and that the interrupt stays quiet when no enable bit is set. Other behaviour can only be shown by the directed scenarios: the exact frame shape against the programmed boundaries, the pin polarities, the point at which a deferred reload takes effect, the cycle on which the line event fires, and the rule that a set wins over a clear in the same cycle.

// File: rtl/acc_tg_pkg.sv
package acc_tg_pkg;
   // register addresses; geometry slots 0..3 double as shadow slot indices
   localparam int          ADDR_W    = 4;
   localparam logic [3:0]  A_SYNC    = 4'd0;
   localparam logic [3:0]  A_BPORCH  = 4'd1;
   localparam logic [3:0]  A_ACTIVE  = 4'd2;
   localparam logic [3:0]  A_TOTAL   = 4'd3;
   localparam logic [3:0]  A_CTRL    = 4'd4;
   localparam logic [3:0]  A_RELOAD  = 4'd5;
   localparam logic [3:0]  A_IEN     = 4'd6;
   localparam logic [3:0]  A_STATUS  = 4'd7;
   localparam logic [3:0]  A_CLEAR   = 4'd8;
   localparam logic [3:0]  A_LINEPOS = 4'd9;

   localparam int NSLOT      = 4;
   localparam int HFIELD_LSB = 16;

   // status flag positions
   localparam int F_LINE   = 0;
   localparam int F_UNDER  = 1;
   localparam int F_XERR   = 2;
   localparam int F_RELOAD = 3;
   localparam int NFLAG    = 4;

   // control word bits
   localparam int C_EN   = 0;
   localparam int C_PCLK = 28;
   localparam int C_DE   = 29;
   localparam int C_VS   = 30;
   localparam int C_HS   = 31;

   // reload request bits
   localparam int RL_NOW = 0;
   localparam int RL_VBL = 1;
endpackage

// File: rtl/acc_tg_regs.sv
module acc_tg_regs
   import acc_tg_pkg::*;
#(
   parameter int HW = 12,
   parameter int VW = 11,
   parameter int DW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DW-1:0]     rd_data,
   input  logic [NFLAG-1:0]  flags,
   input  logic              vbl_point,
   output logic [HW-1:0]     hsw,
   output logic [HW-1:0]     ahbp,
   output logic [HW-1:0]     aaw,
   output logic [HW-1:0]     tw,
   output logic [VW-1:0]     vsh,
   output logic [VW-1:0]     avbp,
   output logic [VW-1:0]     aah,
   output logic [VW-1:0]     th,
   output logic [VW-1:0]     lpos,
   output logic              en,
   output logic              pol_hs,
   output logic              pol_vs,
   output logic              pol_de,
   output logic              pclk_inv,
   output logic [NFLAG-1:0]  ien,
   output logic [NFLAG-1:0]  clr_mask,
   output logic              reload_fire,
   output logic [1:0]        rl_req
);
   logic [NSLOT-1:0][HW-1:0] sh_h, ac_h;
   logic [NSLOT-1:0][VW-1:0] sh_v, ac_v;
   logic [VW-1:0]            sh_lpos, ac_lpos;
   logic [4:0]               ctrl_q;
   logic [NFLAG-1:0]         ien_q;
   logic [1:0]               rl_nxt;
   logic                     unused_wdata;

   assign unused_wdata = ^wr_data;

   // one shadow/working pair per geometry register
   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      logic [HW-1:0] sh_h_q, ac_h_q;
      logic [VW-1:0] sh_v_q, ac_v_q;
      logic          hit;
      assign hit = wr_en && (wr_addr == ADDR_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_h_q <= '0;
            sh_v_q <= '0;
            ac_h_q <= '0;
            ac_v_q <= '0;
         end else begin
            if (hit) begin
               sh_h_q <= wr_data[HFIELD_LSB +: HW];
               sh_v_q <= wr_data[VW-1:0];
            end
            if (reload_fire) begin
               ac_h_q <= sh_h_q;
               ac_v_q <= sh_v_q;
            end
         end
      end
      assign sh_h[g] = sh_h_q;
      assign sh_v[g] = sh_v_q;
      assign ac_h[g] = ac_h_q;
      assign ac_v[g] = ac_v_q;
   end

   assign hsw  = ac_h[0];
   assign vsh  = ac_v[0];
   assign ahbp = ac_h[1];
   assign avbp = ac_v[1];
   assign aaw  = ac_h[2];
   assign aah  = ac_v[2];
   assign tw   = ac_h[3];
   assign th   = ac_v[3];
   assign lpos = ac_lpos;

   assign reload_fire = rl_req[RL_NOW] | (rl_req[RL_VBL] & vbl_point);

   always_comb begin
      rl_nxt = reload_fire ? 2'b00 : rl_req;
      if (wr_en && wr_addr == A_RELOAD) rl_nxt = rl_nxt | wr_data[1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_lpos <= '0;
         ac_lpos <= '0;
         ctrl_q  <= '0;
         ien_q   <= '0;
         rl_req  <= '0;
      end else begin
         rl_req <= rl_nxt;
         if (wr_en && wr_addr == A_LINEPOS) sh_lpos <= wr_data[VW-1:0];
         if (reload_fire) ac_lpos <= sh_lpos;
         if (wr_en && wr_addr == A_CTRL)
            ctrl_q <= {wr_data[C_HS], wr_data[C_VS], wr_data[C_DE],
                       wr_data[C_PCLK], wr_data[C_EN]};
         if (wr_en && wr_addr == A_IEN) ien_q <= wr_data[NFLAG-1:0];
      end
   end

   assign {pol_hs, pol_vs, pol_de, pclk_inv, en} = ctrl_q;
   assign ien      = ien_q;
   assign clr_mask = (wr_en && wr_addr == A_CLEAR) ? wr_data[NFLAG-1:0] : '0;

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_SYNC, A_BPORCH, A_ACTIVE, A_TOTAL: begin
            rd_data[HFIELD_LSB +: HW] = sh_h[rd_addr[1:0]];
            rd_data[VW-1:0]           = sh_v[rd_addr[1:0]];
         end
         A_CTRL: begin
            rd_data[C_HS]   = ctrl_q[4];
            rd_data[C_VS]   = ctrl_q[3];
            rd_data[C_DE]   = ctrl_q[2];
            rd_data[C_PCLK] = ctrl_q[1];
            rd_data[C_EN]   = ctrl_q[0];
         end
         A_RELOAD:  rd_data[1:0]       = rl_req;
         A_IEN:     rd_data[NFLAG-1:0] = ien_q;
         A_STATUS:  rd_data[NFLAG-1:0] = flags;
         A_LINEPOS: rd_data[VW-1:0]    = sh_lpos;
         default:   rd_data = '0;
      endcase
   end
endmodule

// File: rtl/acc_tg_scan.sv
module acc_tg_scan #(
   parameter int HW = 12,
   parameter int VW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [HW-1:0] hsw,
   input  logic [HW-1:0] ahbp,
   input  logic [HW-1:0] aaw,
   input  logic [HW-1:0] tw,
   input  logic [VW-1:0] vsh,
   input  logic [VW-1:0] avbp,
   input  logic [VW-1:0] aah,
   input  logic [VW-1:0] th,
   input  logic [VW-1:0] lpos,
   input  logic          pol_hs,
   input  logic          pol_vs,
   input  logic          pol_de,
   output logic          hs_pin,
   output logic          vs_pin,
   output logic          de_pin,
   output logic [HW-1:0] x,
   output logic [VW-1:0] y,
   output logic          in_window,
   output logic          line_hit,
   output logic          vbl_point
);
   logic line_end, hs_act, vs_act, de_act;

   assign line_end = (x >= tw);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x <= '0;
         y <= '0;
      end else if (!en) begin
         x <= '0;
         y <= '0;
      end else if (line_end) begin
         x <= '0;
         y <= (y >= th) ? '0 : y + 1'b1;
      end else begin
         x <= x + 1'b1;
      end
   end

   assign hs_act = en && (x <= hsw);
   assign vs_act = en && (y <= vsh);
   assign de_act = en && (x > ahbp) && (x <= aaw) && (y > avbp) && (y <= aah);

   assign hs_pin    = pol_hs ? hs_act : ~hs_act;
   assign vs_pin    = pol_vs ? vs_act : ~vs_act;
   assign de_pin    = pol_de ? de_act : ~de_act;
   assign in_window = de_act;
   assign line_hit  = en && (x == '0) && (y == lpos);
   assign vbl_point = en && line_end && (y == aah);
endmodule

// File: rtl/acc_tg_irq.sv
module acc_tg_irq #(
   parameter int NF = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set_vec,
   input  logic [NF-1:0] clr_vec,
   input  logic [NF-1:0] ien,
   output logic [NF-1:0] flags,
   output logic          irq
);
   for (genvar b = 0; b < NF; b++) begin : g_flag
      logic f_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          f_q <= 1'b0;
         else if (set_vec[b]) f_q <= 1'b1;
         else if (clr_vec[b]) f_q <= 1'b0;
      end
      assign flags[b] = f_q;
   end

   assign irq = |(flags & ien);
endmodule

// File: rtl/acc_timing_gen.sv
module acc_timing_gen
   import acc_tg_pkg::*;
#(
   parameter int HW = 12,
   parameter int VW = 11,
   parameter int DW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DW-1:0]     rd_data,
   input  logic              fifo_underrun_i,
   input  logic              xfer_err_i,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              de_o,
   output logic              pclk_inv_o,
   output logic [HW-1:0]     pos_x_o,
   output logic [VW-1:0]     pos_y_o,
   output logic              active_o,
   output logic              irq_o
);
   if (HW < 2 || HW > 12) begin : g_bad_hw
      $error("HW must be within 2..12 to fit the horizontal field");
   end
   if (VW < 2 || VW > 11) begin : g_bad_vw
      $error("VW must be within 2..11 to fit the vertical field");
   end
   if (DW != 32) begin : g_bad_dw
      $error("DW must be 32");
   end

   logic [HW-1:0]    hsw, ahbp, aaw, tw;
   logic [VW-1:0]    vsh, avbp, aah, th, lpos;
   logic             ctrl_en, pol_hs, pol_vs, pol_de;
   logic [NFLAG-1:0] ien, clr_mask, flags, set_vec;
   logic             reload_fire, line_hit, vbl_point;
   logic [1:0]       rl_req;

   acc_tg_regs #(.HW(HW), .VW(VW), .DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .flags(flags), .vbl_point(vbl_point),
      .hsw(hsw), .ahbp(ahbp), .aaw(aaw), .tw(tw),
      .vsh(vsh), .avbp(avbp), .aah(aah), .th(th), .lpos(lpos),
      .en(ctrl_en), .pol_hs(pol_hs), .pol_vs(pol_vs), .pol_de(pol_de),
      .pclk_inv(pclk_inv_o), .ien(ien), .clr_mask(clr_mask),
      .reload_fire(reload_fire), .rl_req(rl_req)
   );

   acc_tg_scan #(.HW(HW), .VW(VW)) u_scan (
      .clk(clk), .rst_n(rst_n), .en(ctrl_en),
      .hsw(hsw), .ahbp(ahbp), .aaw(aaw), .tw(tw),
      .vsh(vsh), .avbp(avbp), .aah(aah), .th(th), .lpos(lpos),
      .pol_hs(pol_hs), .pol_vs(pol_vs), .pol_de(pol_de),
      .hs_pin(hsync_o), .vs_pin(vsync_o), .de_pin(de_o),
      .x(pos_x_o), .y(pos_y_o), .in_window(active_o),
      .line_hit(line_hit), .vbl_point(vbl_point)
   );

   always_comb begin
      set_vec           = '0;
      set_vec[F_LINE]   = line_hit;
      set_vec[F_UNDER]  = fifo_underrun_i;
      set_vec[F_XERR]   = xfer_err_i;
      set_vec[F_RELOAD] = reload_fire;
   end

   acc_tg_irq #(.NF(NFLAG)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .set_vec(set_vec), .clr_vec(clr_mask), .ien(ien),
      .flags(flags), .irq(irq_o)
   );
endmodule

// File: rtl/acc_timing_gen_chk.sv
module acc_timing_gen_chk
   import acc_tg_pkg::*;
#(
   parameter int HW = 12,
   parameter int VW = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              en,
   input logic [1:0]        rl_req,
   input logic [NFLAG-1:0]  flags,
   input logic [NFLAG-1:0]  ien,
   input logic [HW-1:0]     pos_x,
   input logic [VW-1:0]     pos_y,
   input logic              active,
   input logic              irq
);
   p_hold_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (pos_x == '0 && pos_y == '0));

   p_x_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && pos_x != '0) |-> (pos_x == HW'($past(pos_x) + 1'b1)));

   p_y_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && pos_x != '0) |-> $stable(pos_y));

   p_window_off_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (pos_x != '0 && pos_y != '0));

   p_now_req_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rl_req[RL_NOW] && !(wr_en && wr_addr == A_RELOAD)) |=> !rl_req[RL_NOW]);

   p_done_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[F_RELOAD]) |-> ($past(rl_req) != 2'b00));

   p_irq_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == '0) |-> !irq);
endmodule

bind acc_timing_gen acc_timing_gen_chk #(.HW(HW), .VW(VW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .en(ctrl_en), .rl_req(rl_req), .flags(flags), .ien(ien),
   .pos_x(pos_x_o), .pos_y(pos_y_o), .active(active_o), .irq(irq_o)
);

// File: tb/tb_acc_timing_gen.sv
`timescale 1ns/1ps
module tb_acc_timing_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        fifo_underrun_i = 1'b0;
   logic        xfer_err_i = 1'b0;
   logic        hsync_o, vsync_o, de_o, pclk_inv_o, active_o, irq_o;
   logic [11:0] pos_x_o;
   logic [10:0] pos_y_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   acc_timing_gen dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .fifo_underrun_i(fifo_underrun_i), .xfer_err_i(xfer_err_i),
      .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
      .pclk_inv_o(pclk_inv_o), .pos_x_o(pos_x_o), .pos_y_o(pos_y_o),
      .active_o(active_o), .irq_o(irq_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      rd_addr = a;
      #0.5;
      d = rd_data;
   endtask

   task automatic wait_pos(input int x, input int y, input string req);
      bit hit = 0;
      for (int i = 0; i < 400; i++) begin
         if (int'(pos_x_o) == x && int'(pos_y_o) == y) begin
            hit = 1;
            break;
         end
         step();
      end
      chk(hit, req, "position reached", {pos_y_o, 4'h0, pos_x_o}, (y << 16) | x);
   endtask

   // geometry: hsw-1=1 ahbp=3 aaw=7 tw=9 ; vsh=0 avbp=1 aah=4 th=5 ; line pos 5
   task automatic t_reset();
      logic [31:0] d;
      chk(hsync_o == 1'b1 && vsync_o == 1'b1 && de_o == 1'b1, "R8",
          "pins idle after reset", {hsync_o, vsync_o, de_o}, 3'b111);
      chk(pos_x_o == 0 && pos_y_o == 0 && !active_o, "R8", "origin after reset",
          pos_x_o, 0);
      chk(pclk_inv_o == 1'b0, "R7", "pclk select default", pclk_inv_o, 0);
      rd(4'd7, d);
      chk(d == 0 && !irq_o, "R12", "no flags after reset", d, 0);
   endtask

   task automatic t_shadow_now();
      logic [31:0] d;
      wr(4'd0, (32'd1 << 16) | 32'd0);
      wr(4'd1, (32'd3 << 16) | 32'd1);
      wr(4'd2, (32'd7 << 16) | 32'd4);
      wr(4'd3, (32'd9 << 16) | 32'd5);
      wr(4'd9, 32'd5);
      rd(4'd2, d);
      chk(d == ((32'd7 << 16) | 32'd4), "R1", "shadow readback", d, (7 << 16) | 4);
      rd(4'd9, d);
      chk(d == 32'd5, "R1", "line pos readback", d, 5);
      wr(4'd5, 32'h1);
      rd(4'd5, d);
      chk(d == 32'h1, "R2", "immediate request pending", d, 1);
      rd(4'd7, d);
      chk(d[3] == 1'b0, "R2", "reload flag before copy", d, 0);
      step();
      rd(4'd5, d);
      chk(d == 32'h0, "R2", "immediate request cleared", d, 0);
      rd(4'd7, d);
      chk(d[3] == 1'b1, "R2", "reload flag after copy", d, 8);
      wr(4'd8, 32'h8);
      rd(4'd7, d);
      chk(d[3] == 1'b0, "R11", "reload flag cleared", d, 0);
   endtask

   task automatic t_scan();
      int x = 0, y = 0, bad = 0;
      wr(4'd4, 32'h1);
      for (int c = 0; c < 120; c++) begin
         bit win, ok;
         win = (x > 3 && x <= 7 && y > 1 && y <= 4);
         ok = (int'(pos_x_o) == x) && (int'(pos_y_o) == y) &&
              (hsync_o == !(x <= 1)) && (vsync_o == !(y == 0)) &&
              (de_o == !win) && (active_o == win);
         if (!ok && bad < 4) begin
            bad++;
            chk(0, "R4 R5 R6", "scan cycle", {pos_y_o, 4'h0, pos_x_o}, (y << 16) | x);
         end else if (ok) begin
            n_checks++;
         end
         if (x == 9) begin
            x = 0;
            y = (y == 5) ? 0 : y + 1;
         end else begin
            x++;
         end
         step();
      end
   endtask

   task automatic t_polarity();
      wr(4'd4, 32'hF000_0001);
      wait_pos(0, 0, "R7");
      chk(hsync_o == 1 && vsync_o == 1 && de_o == 0 && pclk_inv_o == 1, "R7",
          "active-high pins at origin", {hsync_o, vsync_o, de_o, pclk_inv_o}, 4'b1101);
      wait_pos(5, 3, "R7");
      chk(hsync_o == 0 && vsync_o == 0 && de_o == 1, "R7",
          "active-high pins in window", {hsync_o, vsync_o, de_o}, 3'b001);
      wr(4'd4, 32'h1);
   endtask

   task automatic t_line_event();
      logic [31:0] d;
      wr(4'd8, 32'hF);
      wait_pos(0, 5, "R9");
      rd(4'd7, d);
      chk(d[0] == 1'b0, "R9", "line flag before event edge", d, 0);
      step();
      rd(4'd7, d);
      chk(d[0] == 1'b1, "R9", "line flag set", d, 1);
      chk(irq_o == 1'b0, "R12", "irq masked", irq_o, 0);
      wr(4'd6, 32'h1);
      chk(irq_o == 1'b1, "R12", "irq with enabled flag", irq_o, 1);
      wr(4'd6, 32'h0);
      chk(irq_o == 1'b0, "R12", "irq after disable", irq_o, 0);
      wr(4'd8, 32'hF);
   endtask

   task automatic t_vbl_reload();
      logic [31:0] d;
      wr(4'd3, (32'd11 << 16) | 32'd5);
      wait_pos(9, 1, "R1");
      step();
      chk(pos_x_o == 0 && pos_y_o == 2, "R1", "shadow total not yet in use",
          {pos_y_o, 4'h0, pos_x_o}, 2 << 16);
      wr(4'd5, 32'h2);
      rd(4'd5, d);
      chk(d == 32'h2, "R3", "deferred request pending", d, 2);
      wr(4'd8, 32'hF);
      wait_pos(9, 4, "R3");
      rd(4'd7, d);
      chk(d[3] == 1'b0, "R3", "no copy before blanking edge", d, 0);
      step();
      chk(pos_x_o == 0 && pos_y_o == 5, "R3", "first blanking line",
          {pos_y_o, 4'h0, pos_x_o}, 5 << 16);
      rd(4'd7, d);
      chk(d[3] == 1'b1, "R3", "copy at blanking edge", d, 8);
      rd(4'd5, d);
      chk(d == 32'h0, "R3", "deferred request cleared", d, 0);
      wait_pos(11, 5, "R3");
      step();
      chk(pos_x_o == 0 && pos_y_o == 0, "R3", "wider line wraps", {pos_y_o, 4'h0, pos_x_o}, 0);
   endtask

   task automatic t_err_flags();
      logic [31:0] d;
      wr(4'd8, 32'hF);
      fifo_underrun_i = 1'b1;
      step();
      fifo_underrun_i = 1'b0;
      rd(4'd7, d);
      chk(d[1] == 1'b1, "R10", "underrun flag", d, 2);
      wr(4'd6, 32'h2);
      chk(irq_o == 1'b1, "R12", "irq from underrun", irq_o, 1);
      xfer_err_i = 1'b1;
      step();
      xfer_err_i = 1'b0;
      rd(4'd7, d);
      chk(d[2] == 1'b1, "R10", "transfer error flag", d, 4);
      wr(4'd8, 32'h2);
      rd(4'd7, d);
      chk(d[1] == 1'b0 && d[2] == 1'b1, "R11", "selective clear", d, 4);
      chk(irq_o == 1'b0, "R12", "irq after clear", irq_o, 0);
      fifo_underrun_i = 1'b1;
      wr(4'd8, 32'h2);
      fifo_underrun_i = 1'b0;
      rd(4'd7, d);
      chk(d[1] == 1'b1, "R11", "event wins over clear", d, 6);
      wr(4'd6, 32'h0);
   endtask

   task automatic t_disable();
      wait_pos(6, 3, "R8");
      wr(4'd4, 32'h0);
      chk(hsync_o == 1 && vsync_o == 1 && de_o == 1 && !active_o, "R8",
          "pins idle at once", {hsync_o, vsync_o, de_o, active_o}, 4'b1110);
      step();
      chk(pos_x_o == 0 && pos_y_o == 0, "R8", "origin after disable",
          {pos_y_o, 4'h0, pos_x_o}, 0);
      for (int i = 0; i < 5; i++) step();
      chk(pos_x_o == 0 && pos_y_o == 0, "R8", "origin held", {pos_y_o, 4'h0, pos_x_o}, 0);
   endtask

   bit done = 0;

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_shadow_now();
      t_scan();
      t_polarity();
      t_line_event();
      t_vbl_reload();
      t_err_flags();
      t_disable();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule